// File: doc/BRIEF.md
# Two-Level Programmable Sample Delay

This block delays a wideband sample stream by a whole number of samples that software chooses. The stream arrives already split into parallel lanes, so each system-clock cycle carries one word of `LANES` consecutive samples. Lane 0 holds the earliest sample of the word. With the default 64 lanes at an 8.192 GS/s sample rate, one sample step is about 0.122 ns and one word period is 7.8125 ns.

The delay has two parts. The fine part picks which input sample starts each output word. It does this by taking a window of `LANES` samples across the current word and the previous one, which stands in for choosing the phase of the divided clock. The fine step is one sample. The coarse part writes every aligned word into a circular RAM at the system clock rate. It reads the RAM back `word_lag` words behind the write pointer, so the coarse step is one whole word.

The total delay is `LANES*word_lag + phase_sel` samples, on top of a fixed one-cycle register stage. The block sits between the lane demultiplexer and the channelizer. After any change to the delay setting, the output valid flag stays low until the ring holds enough words written under the new setting.

Top module: `sample_delay_2lvl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `out_valid` is 0 and `out_word` is all zeros.
- R2: Input samples are numbered continuously, with word w lane j being sample `w*LANES+j`. When word w is accepted and its output is valid, lane j of `out_word` equals input sample `w*LANES + j - LANES*word_lag - phase_sel`.
- R3: With `phase_sel` = p > 0, output lanes 0..p-1 come from the last p lanes of the previous input word, and lanes p..LANES-1 come from the current word shifted up by p lanes. This holds up to p = LANES-1.
- R4: `word_lag` can take any value from 0 to DEPTH-1. The largest lag reads the word written DEPTH-1 words earlier, and the read pointer wraps modulo DEPTH (a power of two).
- R5: The output for a word accepted in cycle t appears in cycle t+1. With both settings at 0, `out_word` is the input word of the previous cycle, unchanged.
- R6: The delay counts accepted words, not cycles. A cycle with `in_valid` low advances no pointer, and `out_valid` is 0 in the following cycle.
- R7: A word accepted in a cycle where `phase_sel` or `word_lag` differs from its value in the previous cycle gives `out_valid` = 0. After that, `out_valid` stays 0 until more than `word_lag` words have been accepted with the new setting held.
- R8: `out_word` keeps its value through cycles that follow a cycle with no accepted word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one word per cycle |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present this cycle |
| in_word | input | LANES*SW | Input word; lane j at bits [j*SW +: SW], lane 0 earliest |
| phase_sel | input | $clog2(LANES) | Fine delay in samples |
| word_lag | input | $clog2(DEPTH) | Coarse delay in words |
| out_valid | output | 1 | Delayed word valid |
| out_word | output | LANES*SW | Delayed word, same lane order |

## Verification
The input is a counting ramp: each lane carries its own sample index. Any output lane therefore shows exactly which input sample it came from, so a fine error by one sample and a coarse error by one word give different values. The stimulus steps through fine settings of 0, 1, mid-word and LANES-1. This separates correct boundary-crossing from a window that is off by one lane. Coarse settings of 0, small values and DEPTH-1 separate the bypass path, ordinary ring reads and pointer wrap. Idle gaps inside runs, and a setting change on a valid word, show whether delay is counted in words and whether output is blanked for the right number of words.

// File: rtl/sample_delay_2lvl.sv
module sample_delay_2lvl #(
  parameter int LANES = 64,
  parameter int SW    = 8,
  parameter int DEPTH = 256,
  localparam int FW  = $clog2(LANES),
  localparam int CW  = $clog2(DEPTH),
  localparam int WW  = LANES * SW,
  localparam int SHW = $clog2(2 * WW) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [WW-1:0] in_word,
  input  logic [FW-1:0] phase_sel,
  input  logic [CW-1:0] word_lag,
  output logic          out_valid,
  output logic [WW-1:0] out_word
);

  localparam logic [CW:0] FILL_MAX = (CW + 1)'(DEPTH);

  logic [FW-1:0]   phase_q;
  logic [CW-1:0]   lag_q;
  logic [CW-1:0]   wptr;
  logic [CW-1:0]   rptr;
  logic [CW:0]     fill;
  logic [WW-1:0]   prev_q;
  logic [WW-1:0]   aligned;
  logic [2*WW-1:0] pair;
  logic [SHW-1:0]  shamt;
  logic            changed;
  logic [WW-1:0]   ring [DEPTH];

  assign changed = (phase_sel != phase_q) || (word_lag != lag_q);
  assign pair    = {in_word, prev_q};
  assign shamt   = SHW'(WW) - SHW'(phase_q) * SHW'(SW);
  assign aligned = WW'(pair >> shamt);
  assign rptr    = wptr - lag_q;

  always_ff @(posedge clk) begin
    if (in_valid) ring[wptr] <= aligned;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= '0;
      lag_q     <= '0;
      wptr      <= '0;
      fill      <= '0;
      prev_q    <= '0;
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      phase_q   <= phase_sel;
      lag_q     <= word_lag;
      out_valid <= in_valid && !changed && (fill > {1'b0, lag_q});
      if (changed)
        fill <= '0;
      else if (in_valid && fill != FILL_MAX)
        fill <= fill + 1'b1;
      if (in_valid) begin
        prev_q   <= in_word;
        wptr     <= wptr + 1'b1;
        out_word <= (lag_q == '0) ? aligned : ring[rptr];
      end
    end
  end

endmodule

// File: rtl/sample_delay_2lvl_chk.sv
module sample_delay_2lvl_chk #(
  parameter int LANES = 64,
  parameter int SW    = 8,
  parameter int DEPTH = 256,
  localparam int FW = $clog2(LANES),
  localparam int CW = $clog2(DEPTH),
  localparam int WW = LANES * SW
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [WW-1:0] in_word,
  input logic [FW-1:0] phase_sel,
  input logic [CW-1:0] word_lag,
  input logic          out_valid,
  input logic [WW-1:0] out_word
);

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  assert_valid_follows_input_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  assert_change_blanks_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (phase_sel != $past(phase_sel) || word_lag != $past(word_lag))) |=> !out_valid);

  assert_passthrough_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && phase_sel == '0 && word_lag == '0 &&
     $past(phase_sel) == '0 && $past(word_lag) == '0) |=> out_word == $past(in_word));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(in_valid) && !$past(rst)) |-> $stable(out_word));

endmodule

bind sample_delay_2lvl sample_delay_2lvl_chk #(.LANES(LANES), .SW(SW), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
  .phase_sel(phase_sel), .word_lag(word_lag),
  .out_valid(out_valid), .out_word(out_word)
);

// File: tb/sample_delay_2lvl_tb_top.sv
module sample_delay_2lvl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 64;
  localparam int SW    = 16;
  localparam int DEPTH = 256;
  localparam int WW    = LANES * SW;
  localparam int NVEC  = 9;
  localparam int VEC [NVEC][3] = '{
    '{0, 0, 6},     // R5 bypass
    '{1, 0, 8},     // R3 one-sample shift
    '{63, 0, 8},    // R3 largest fine step
    '{5, 3, 12},    // R2 mixed
    '{0, 7, 14},    // R2 coarse only
    '{32, 1, 10},   // R3 half word
    '{17, 255, 262},// R4 largest lag, wrap
    '{0, 2, 8},     // R2 small lag
    '{40, 9, 16}    // R2 mixed
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [WW-1:0] in_word = '0;
  logic [5:0]    phase_sel = '0;
  logic [7:0]    word_lag = '0;
  logic          out_valid;
  logic [WW-1:0] out_word;

  int checks = 0;
  int errors = 0;
  int raw_idx = 0;
  int since = 0;
  int cur_f = 0;
  int cur_c = 0;
  logic [WW-1:0] last_out = '0;

  sample_delay_2lvl #(.LANES(LANES), .SW(SW), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .phase_sel(phase_sel), .word_lag(word_lag),
    .out_valid(out_valid), .out_word(out_word)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic step(input bit v, input int f, input int c, input string req);
    bit chg;
    bit expv;
    logic [WW-1:0] expw;
    chg = (f != cur_f) || (c != cur_c);
    @(negedge clk);
    in_valid  = v;
    phase_sel = 6'(f);
    word_lag  = 8'(c);
    for (int j = 0; j < LANES; j++) in_word[j*SW +: SW] = SW'(raw_idx * LANES + j);
    @(posedge clk);
    #1;
    expv = 1'b0;
    if (chg) begin
      cur_f = f;
      cur_c = c;
      since = 0;
    end else if (v) begin
      expv = (since > c);
      since++;
    end
    checks++;
    if (out_valid !== expv) begin
      errors++;
      $display("FAIL %s valid word=%0d: actual=%0b expected=%0b", req, raw_idx, out_valid, expv);
    end
    if (v && expv) begin
      for (int j = 0; j < LANES; j++)
        expw[j*SW +: SW] = SW'(raw_idx * LANES + j - LANES * c - f);
      checks++;
      if (out_word !== expw) begin
        errors++;
        $display("FAIL %s data word=%0d f=%0d c=%0d: actual lane0=%0d expected lane0=%0d",
                 req, raw_idx, f, c, out_word[SW-1:0], expw[SW-1:0]);
      end
    end
    if (!v) begin
      checks++;
      if (out_word !== last_out) begin
        errors++;
        $display("FAIL R8 hold: actual lane0=%0d expected lane0=%0d", out_word[SW-1:0], last_out[SW-1:0]);
      end
    end
    last_out = out_word;
    if (v) raw_idx++;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || out_word !== '0) begin
      errors++;
      $display("FAIL R1 during reset: actual v=%0b expected v=0", out_valid);
    end
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b0 || out_word !== '0) begin
      errors++;
      $display("FAIL R1 after release: actual v=%0b expected v=0", out_valid);
    end
    last_out = out_word;

    for (int e = 0; e < NVEC; e++) begin
      step(1'b0, VEC[e][0], VEC[e][1], "R7");
      for (int k = 0; k < VEC[e][2]; k++) begin
        if (k % 5 == 2) step(1'b0, VEC[e][0], VEC[e][1], "R6");
        step(1'b1, VEC[e][0], VEC[e][1], "R2/R3/R4/R5");
      end
    end

    // R7: setting change on a valid word, then refill for lag 2
    step(1'b1, 0, 2, "R7");
    step(1'b1, 0, 2, "R7");
    step(1'b1, 4, 2, "R7");
    for (int k = 0; k < 6; k++) step(1'b1, 4, 2, "R7");

    // R6: idle burst does not advance the ring
    for (int k = 0; k < 3; k++) step(1'b0, 4, 2, "R6");
    for (int k = 0; k < 3; k++) step(1'b1, 4, 2, "R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule